// File: doc/BRIEF.md
# Hybrid Product-Term Array

This block is a configurable sum-of-products plane. A bank of true inputs is expanded into both polarities. Those literals feed a programmable AND plane, which forms three kinds of product term. Each output has its own small group of dedicated terms, and those terms reach that output through a fixed OR. A shared pool of terms can reach any output through a programmable OR matrix, and one pool term may drive several outputs at once. A handful of control lines can each be set to form either an AND or an OR of the literals connected to it.

The whole personality sits in registers. It is loaded one row at a time through an address/data write port with a write enable. A separate read address returns any stored row combinationally. Once loaded, the path from `dataIn` to `sumOut` and `ctlOut` holds no register, so results follow the inputs without a clock. By default there are 36 inputs, 16 outputs, 5 dedicated terms per output, 32 pool terms and 6 control lines. The pool size and the control-line count must not exceed twice the input count.

Address map, with DED = outputs × dedicated terms:

- Rows 0 to DED-1 are the dedicated terms. Output o, term k, sits at row o·(dedicated terms)+k.
- The next pool-size rows are the pool terms.
- The next rows are the control lines.
- After those, one row per output holds that output's pool enables.
- The last row is the control-mode word.
- Any higher address is unmapped.

Top module: `hpla_array`

## Requirements
- R1: In an AND-plane row, bit 2i connects input i in true polarity and bit 2i+1 connects its complement. A literal whose two bits are both clear does not affect the term. A term with both polarities of one input connected is always 0.
- R2: Dedicated row o·DED_PT+k is ORed into output o only, with no configuration needed beyond the row itself.
- R3: Pool term p drives output o when bit p of output o's OR-enable row is set. One pool term may be enabled on several outputs at once. A pool term that is not enabled on an output has no effect there.
- R4: A single output can combine all of its dedicated terms and the entire pool at once (37 terms with default sizes).
- R5: A product term with no connected literal evaluates to 0. An output whose dedicated rows are empty and whose enable row is clear is 0.
- R6: Control line c takes its connections from the AND-plane row after the pool. Bit c of the mode word selects how it combines them: 0 means the AND of the connected literals, 1 means their OR. With no literal connected, the line is 0 in both modes.
- R7: Reset clears every configuration bit, so every output and every read-back value is 0.
- R8: A write stores the data at its address on the clock edge. Read-back returns the stored value. Enable and mode rows keep only their low pool-size and control-count bits and read back zero above them. A write to an unmapped address changes nothing, and a read from one returns 0.
- R9: Outputs follow a change of `dataIn` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset, clears configuration |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 8 | Configuration write row address |
| cfgWdata | input | 72 | Configuration write data |
| cfgRaddr | input | 8 | Read-back row address |
| cfgRdata | output | 72 | Read-back data, combinational |
| dataIn | input | 36 | True inputs to the array |
| sumOut | output | 16 | Output sum lines |
| ctlOut | output | 6 | Control-term lines |

## Verification
The bench shrinks the array to 4 inputs, 3 outputs, 2 dedicated terms, 4 pool terms and 2 control lines, so every one of the 16 input codes can be swept after each configuration change.

Hand-built configurations each isolate one behaviour:
- a single true/complement literal pair, and a row with both polarities of one input, which separates polarity decoding from a stuck row;
- a pool term enabled on two outputs beside one left disabled, which tells steering from broadcasting;
- an output loaded with all of its terms;
- control lines flipped between the AND and OR modes.

Sparse random personalities then exercise mixed overlaps. A full read-back scan, unmapped writes and a mid-run reset show that stored state changes only where it should.

// File: rtl/hpla_pkg.sv
package hpla_pkg;

  // Write strobes the control decoder hands to the storage planes.
  typedef struct packed {
    logic andWe;
    logic orWe;
    logic modeWe;
  } cfg_strobe_t;

  // Which plane answers a read-back request.
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_AND  = 2'd1,
    RD_OR   = 2'd2,
    RD_MODE = 2'd3
  } rd_sel_t;

endpackage

// File: rtl/hpla_ctrl.sv
module hpla_ctrl
  import hpla_pkg::*;
#(
  parameter int AND_ROWS = 118,
  parameter int NUM_OUT  = 16,
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfgWe,
  input  logic [ADDR_W-1:0]   cfgAddr,
  input  logic [ADDR_W-1:0]   cfgRaddr,
  output cfg_strobe_t         strobe,
  output logic [IDX_W-1:0]    wrIdx,
  output rd_sel_t             rdSel,
  output logic [IDX_W-1:0]    rdIdx
);

  localparam logic [ADDR_W-1:0] OR_BASE = ADDR_W'(AND_ROWS);
  localparam logic [ADDR_W-1:0] MODE_A  = ADDR_W'(AND_ROWS + NUM_OUT);

  // Write decode: an unmapped address raises no strobe.
  always_comb begin
    strobe = '0;
    wrIdx  = '0;
    if (cfgWe) begin
      if (cfgAddr < OR_BASE) begin
        strobe.andWe = 1'b1;
        wrIdx        = IDX_W'(cfgAddr);
      end else if (cfgAddr < MODE_A) begin
        strobe.orWe = 1'b1;
        wrIdx       = IDX_W'(cfgAddr - OR_BASE);
      end else if (cfgAddr == MODE_A) begin
        strobe.modeWe = 1'b1;
      end
    end
  end

  // Read decode.
  always_comb begin
    rdSel = RD_NONE;
    rdIdx = '0;
    if (cfgRaddr < OR_BASE) begin
      rdSel = RD_AND;
      rdIdx = IDX_W'(cfgRaddr);
    end else if (cfgRaddr < MODE_A) begin
      rdSel = RD_OR;
      rdIdx = IDX_W'(cfgRaddr - OR_BASE);
    end else if (cfgRaddr == MODE_A) begin
      rdSel = RD_MODE;
    end
  end

  // R8: at most one plane is written per cycle
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.andWe, strobe.orWe, strobe.modeWe}));

  // R8: an unmapped write address never raises a strobe
  a_r8_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgAddr > MODE_A) |-> (strobe == '0));

endmodule

// File: rtl/hpla_andplane.sv
module hpla_andplane #(
  parameter int NUM_IN  = 36,
  parameter int ROWS    = 118,
  parameter int CT_BASE = 112,
  parameter int NUM_CT  = 6,
  parameter int IDX_W   = 7,
  localparam int DW     = 2 * NUM_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DW-1:0]     wdata,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DW-1:0]     rdData,
  input  logic [NUM_IN-1:0] dataIn,
  output logic [ROWS-1:0]   prodOut,
  output logic [NUM_CT-1:0] ctHit
);

  logic [DW-1:0] rowCfg [ROWS];
  logic [DW-1:0] lits;

  // Literal bus: even bit true polarity, odd bit complement.
  for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
    assign lits[2*i]   = dataIn[i];
    assign lits[2*i+1] = ~dataIn[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) rowCfg[r] <= '0;
    end else if (we) begin
      rowCfg[wrIdx] <= wdata;
    end
  end

  assign rdData = rowCfg[rdIdx];

  function automatic logic polClash(input logic [DW-1:0] c);
    logic clash;
    clash = 1'b0;
    for (int i = 0; i < NUM_IN; i++) clash = clash | (c[2*i] & c[2*i+1]);
    return clash;
  endfunction

  // Product rows: AND of connected literals, 0 when nothing connected.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign prodOut[r] = (|rowCfg[r]) & (&(~rowCfg[r] | lits));

    // R5: an empty row never asserts
    a_r5_empty_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rowCfg[r] == '0) |-> !prodOut[r]);

    // R1: both polarities of one input forces the term low
    a_r1_clash_zero: assert property (@(posedge clk) disable iff (!rst_n)
      polClash(rowCfg[r]) |-> !prodOut[r]);
  end

  // Control rows also report whether any connected literal is true.
  for (genvar c = 0; c < NUM_CT; c++) begin : g_hit
    assign ctHit[c] = |(rowCfg[CT_BASE+c] & lits);
  end

  // R8: a written row holds the written data on the next cycle
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rowCfg[$past(wrIdx)] == $past(wdata)));

endmodule

// File: rtl/hpla_orplane.sv
module hpla_orplane #(
  parameter int NUM_OUT = 16,
  parameter int DED_PT  = 5,
  parameter int POOL_PT = 32,
  parameter int NUM_CT  = 6,
  parameter int DW      = 72,
  parameter int IDX_W   = 7,
  localparam int NDED   = NUM_OUT * DED_PT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               orWe,
  input  logic               modeWe,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [POOL_PT-1:0] enData,
  input  logic [NUM_CT-1:0]  modeData,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [DW-1:0]      rdOrData,
  output logic [DW-1:0]      rdModeData,
  input  logic [NDED-1:0]    dedPt,
  input  logic [POOL_PT-1:0] poolPt,
  input  logic [NUM_CT-1:0]  ctProd,
  input  logic [NUM_CT-1:0]  ctHit,
  output logic [NUM_OUT-1:0] sumOut,
  output logic [NUM_CT-1:0]  ctlOut
);

  logic [POOL_PT-1:0] orEn [NUM_OUT];
  logic [NUM_CT-1:0]  ctMode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int o = 0; o < NUM_OUT; o++) orEn[o] <= '0;
      ctMode <= '0;
    end else begin
      if (orWe)   orEn[wrIdx] <= enData;
      if (modeWe) ctMode      <= modeData;
    end
  end

  assign rdOrData   = DW'(orEn[rdIdx]);
  assign rdModeData = DW'(ctMode);

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic dedAny;
    logic poolAny;
    assign dedAny    = |dedPt[o*DED_PT +: DED_PT];
    assign poolAny   = |(poolPt & orEn[o]);
    assign sumOut[o] = dedAny | poolAny;

    // R2: any dedicated term of this output drives it high
    a_r2_ded_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (|dedPt[o*DED_PT +: DED_PT]) |-> sumOut[o]);

    // R3: an enabled, active pool term drives this output high
    a_r3_pool_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (|(poolPt & orEn[o])) |-> sumOut[o]);

    // R5: nothing connected and no dedicated term active keeps it low
    a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      ((orEn[o] == '0) && !(|dedPt[o*DED_PT +: DED_PT])) |-> !sumOut[o]);
  end

  for (genvar c = 0; c < NUM_CT; c++) begin : g_ct
    assign ctlOut[c] = ctMode[c] ? ctHit[c] : ctProd[c];

    // R6: in either mode a high line needs a true connected literal
    a_r6_needs_literal: assert property (@(posedge clk) disable iff (!rst_n)
      ctlOut[c] |-> ctHit[c]);
  end

endmodule

// File: rtl/hpla_array.sv
module hpla_array
  import hpla_pkg::*;
#(
  parameter int NUM_IN   = 36,
  parameter int NUM_OUT  = 16,
  parameter int DED_PT   = 5,
  parameter int POOL_PT  = 32,
  parameter int NUM_CT   = 6,
  localparam int NDED     = NUM_OUT * DED_PT,
  localparam int CT_BASE  = NDED + POOL_PT,
  localparam int AND_ROWS = CT_BASE + NUM_CT,
  localparam int TOTAL    = AND_ROWS + NUM_OUT + 1,
  localparam int ADDR_W   = $clog2(TOTAL + 1),
  localparam int DATA_W   = 2 * NUM_IN,
  localparam int IDX_W    = $clog2(AND_ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWdata,
  input  logic [ADDR_W-1:0]  cfgRaddr,
  output logic [DATA_W-1:0]  cfgRdata,
  input  logic [NUM_IN-1:0]  dataIn,
  output logic [NUM_OUT-1:0] sumOut,
  output logic [NUM_CT-1:0]  ctlOut
);

  cfg_strobe_t           strobe;
  rd_sel_t               rdSel;
  logic [IDX_W-1:0]      wrIdx;
  logic [IDX_W-1:0]      rdIdx;
  logic [AND_ROWS-1:0]   prodAll;
  logic [NUM_CT-1:0]     ctHit;
  logic [DATA_W-1:0]     andRd;
  logic [DATA_W-1:0]     orRd;
  logic [DATA_W-1:0]     modeRd;

  hpla_ctrl #(
    .AND_ROWS(AND_ROWS), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgRaddr(cfgRaddr), .strobe(strobe), .wrIdx(wrIdx),
    .rdSel(rdSel), .rdIdx(rdIdx)
  );

  hpla_andplane #(
    .NUM_IN(NUM_IN), .ROWS(AND_ROWS), .CT_BASE(CT_BASE),
    .NUM_CT(NUM_CT), .IDX_W(IDX_W)
  ) u_and (
    .clk(clk), .rst_n(rst_n), .we(strobe.andWe), .wrIdx(wrIdx),
    .wdata(cfgWdata), .rdIdx(rdIdx), .rdData(andRd), .dataIn(dataIn),
    .prodOut(prodAll), .ctHit(ctHit)
  );

  hpla_orplane #(
    .NUM_OUT(NUM_OUT), .DED_PT(DED_PT), .POOL_PT(POOL_PT),
    .NUM_CT(NUM_CT), .DW(DATA_W), .IDX_W(IDX_W)
  ) u_or (
    .clk(clk), .rst_n(rst_n), .orWe(strobe.orWe), .modeWe(strobe.modeWe),
    .wrIdx(wrIdx), .enData(cfgWdata[POOL_PT-1:0]),
    .modeData(cfgWdata[NUM_CT-1:0]), .rdIdx(rdIdx),
    .rdOrData(orRd), .rdModeData(modeRd),
    .dedPt(prodAll[NDED-1:0]), .poolPt(prodAll[NDED +: POOL_PT]),
    .ctProd(prodAll[CT_BASE +: NUM_CT]), .ctHit(ctHit),
    .sumOut(sumOut), .ctlOut(ctlOut)
  );

  always_comb begin
    unique case (rdSel)
      RD_AND:  cfgRdata = andRd;
      RD_OR:   cfgRdata = orRd;
      RD_MODE: cfgRdata = modeRd;
      default: cfgRdata = '0;
    endcase
  end

endmodule

// File: tb/hpla_array_test.sv
module hpla_array_test;

  localparam int NI = 4, NO = 3, ND = 2, NP = 4, NC = 2;
  localparam int DW = 2 * NI;
  localparam int POOL0 = NO * ND;
  localparam int CT0 = POOL0 + NP;
  localparam int ANDR = CT0 + NC;
  localparam int ORB = ANDR;
  localparam int MODEA = ANDR + NO;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWe = 1'b0;
  logic [AW-1:0] cfgAddr = '0;
  logic [DW-1:0] cfgWdata = '0;
  logic [AW-1:0] cfgRaddr = '0;
  logic [DW-1:0] cfgRdata;
  logic [NI-1:0] dataIn = '0;
  logic [NO-1:0] sumOut;
  logic [NC-1:0] ctlOut;

  int nChecks = 0;
  int nFails = 0;

  logic [DW-1:0] mAnd [ANDR];
  logic [NP-1:0] mOr  [NO];
  logic [NC-1:0] mMode;

  always #2.5 clk = ~clk;

  hpla_array #(.NUM_IN(NI), .NUM_OUT(NO), .DED_PT(ND), .POOL_PT(NP), .NUM_CT(NC)) uut (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRaddr(cfgRaddr), .cfgRdata(cfgRdata),
    .dataIn(dataIn), .sumOut(sumOut), .ctlOut(ctlOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int r = 0; r < ANDR; r++) mAnd[r] = '0;
    for (int o = 0; o < NO; o++) mOr[o] = '0;
    mMode = '0;
  endtask

  task automatic wr(input int addr, input logic [DW-1:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = AW'(addr); cfgWdata = d;
    @(posedge clk);
    #1 cfgWe = 1'b0;
    if (addr < ORB) mAnd[addr] = d;
    else if (addr < MODEA) mOr[addr-ORB] = d[NP-1:0];
    else if (addr == MODEA) mMode = d[NC-1:0];
  endtask

  function automatic logic [NO+NC-1:0] model(input logic [NI-1:0] v);
    logic [DW-1:0] lit;
    logic [ANDR-1:0] prod;
    logic [ANDR-1:0] hit;
    logic [NO-1:0] s;
    logic [NC-1:0] c;
    for (int i = 0; i < NI; i++) begin
      lit[2*i] = v[i];
      lit[2*i+1] = ~v[i];
    end
    for (int r = 0; r < ANDR; r++) begin
      prod[r] = (mAnd[r] != 0) && ((~mAnd[r] | lit) == {DW{1'b1}});
      hit[r]  = (mAnd[r] & lit) != 0;
    end
    for (int o = 0; o < NO; o++) begin
      s[o] = 1'b0;
      for (int k = 0; k < ND; k++) s[o] = s[o] | prod[o*ND+k];
      for (int p = 0; p < NP; p++) s[o] = s[o] | (mOr[o][p] & prod[POOL0+p]);
    end
    for (int k = 0; k < NC; k++) c[k] = mMode[k] ? hit[CT0+k] : prod[CT0+k];
    return {c, s};
  endfunction

  task automatic sweep(input string req);
    for (int v = 0; v < 16; v++) begin
      logic [NO+NC-1:0] e;
      dataIn = NI'(v);
      #0.5;
      e = model(NI'(v));
      chk({ctlOut, sumOut} == e, req, int'({ctlOut, sumOut}), int'(e));
    end
  endtask

  task automatic scanRead(input string req);
    for (int a = 0; a < 32; a++) begin
      logic [DW-1:0] e;
      cfgRaddr = AW'(a);
      #0.5;
      if (a < ORB) e = mAnd[a];
      else if (a < MODEA) e = DW'(mOr[a-ORB]);
      else if (a == MODEA) e = DW'(mMode);
      else e = '0;
      chk(cfgRdata == e, req, int'(cfgRdata), int'(e));
    end
  endtask

  initial begin
    #500000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    modelClear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R7: reset state, outputs and read-back all zero
    sweep("R7 reset outputs");
    scanRead("R7 reset readback");

    // R1: true in0, complement in1 on output 0 term 0 (bits 0 and 3)
    wr(0, 8'b0000_1001);
    // R1: both polarities of in2 on output 0 term 1 never fires
    wr(1, 8'b0011_0000);
    sweep("R1 polarity");

    // R2: output 1 second dedicated term = in3 (bit 6)
    wr(1*ND+1, 8'b0100_0000);
    sweep("R2 dedicated");

    // R3: pool 0 = in0&in1 on out0 and out2; pool 1 = ~in2 on out1; pool 2 unused
    wr(POOL0+0, 8'b0000_0101);
    wr(POOL0+1, 8'b0010_0000);
    wr(POOL0+2, 8'b0000_0010);
    wr(ORB+0, 8'h01);
    wr(ORB+1, 8'h02);
    wr(ORB+2, 8'h01);
    sweep("R3 shared steering");

    // R4: output 2 takes both dedicated terms and the whole pool
    wr(2*ND+0, 8'b1000_0000);
    wr(2*ND+1, 8'b0000_1000);
    wr(POOL0+3, 8'b0100_0001);
    wr(ORB+2, 8'hFF);
    sweep("R4 full output");

    // R6: ct0 = in0|in1 in OR mode, ct1 = in2&~in3 in AND mode
    wr(CT0+0, 8'b0000_0101);
    wr(CT0+1, 8'b1001_0000);
    wr(MODEA, 8'b0000_0001);
    sweep("R6 control modes");
    wr(MODEA, 8'b0000_0010);
    sweep("R6 control modes swapped");
    wr(CT0+0, 8'h00);
    wr(MODEA, 8'b0000_0011);
    sweep("R6 empty control line");

    // R5: clear all pool enables and a dedicated row
    wr(ORB+0, 8'h00);
    wr(0, 8'h00);
    sweep("R5 empty terms");

    // R8: read-back, masked high bits, unmapped writes
    scanRead("R8 readback");
    wr(MODEA+1, 8'hFF);
    wr(31, 8'hFF);
    sweep("R8 unmapped write ignored");
    scanRead("R8 readback after unmapped write");

    // R9: input change seen with no clock edge
    @(negedge clk);
    dataIn = 4'b0011;
    #1;
    begin
      logic [NO+NC-1:0] e;
      e = model(4'b0011);
      chk({ctlOut, sumOut} == e, "R9 combinational", int'({ctlOut, sumOut}), int'(e));
    end

    // R1 R2 R3 R6: sparse random personalities
    for (int t = 0; t < 20; t++) begin
      for (int a = 0; a <= MODEA; a++) wr(a, DW'($urandom & $urandom & $urandom));
      sweep("R3 random personality");
    end
    scanRead("R8 random readback");

    // R7: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    modelClear();
    sweep("R7 reset mid-run outputs");
    scanRead("R7 reset mid-run readback");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule